// File: doc/BRIEF.md
# Reset Cause and Source Enable Register

This block combines a small reset controller with one 8-bit control register on the processor's register bus. Seven events can reset the system: power-on, a supply-monitor trip, the external reset pin, a watchdog timeout, a missing-clock timeout, a comparator trip and a flash access error. Software can also force a reset by writing to the register. The block decides which of these events may reset the chip and raises a system reset request for a fixed number of clock cycles. It also records which event caused that reset.

Four bit positions of the register do two jobs. A normal read returns the reset cause flag at that position. A write sets the enable for the matching reset source. The read half of a read-modify-write access returns the enables instead of the flags at those positions, so the write half puts the enables back unchanged. The watchdog, pin and flash-error positions are read-only cause flags. The top bit is unused.

Power-on is an asynchronous input. It resets the register on its own and does not depend on any enable. Every other event is sampled on the rising clock edge.

Top module: `rst_cause_reg`

## Requirements
- R1: Register bit 7 always reads 0, and writing 1 to it changes nothing.
- R2: While power-on is asserted, the reset request is high at once, without waiting for a clock edge. Afterwards a normal read returns 0x02, meaning the power flag in bit 1. The supply-monitor enable (bit 1) is 1, and the missing-clock enable (bit 2) and comparator enable (bit 5) are 0.
- R3: The reset request rises after the clock edge that accepts a trigger. It stays high for exactly 16 cycles, then falls. After power-on is released, the request also stays high for 16 more cycles.
- R4: The pin, watchdog and flash-error inputs always cause a reset. They set cause flags in bit 0, bit 3 and bit 6 respectively.
- R5: Writing 1 to bit 4 forces a reset, and bit 4 then reads as the cause flag. Writing 0 to bit 4 has no effect.
- R6: Bit 2 enables the missing-clock timeout as a reset source. The timeout causes a reset, and sets flag bit 2, only while that enable is 1.
- R7: Bit 5 enables the comparator as a reset source. The comparator input is active low. A low level causes a reset, and sets flag bit 5, only while that enable is 1.
- R8: Bit 1 enables the supply-monitor trip as a reset source. An enabled trip sets flag bit 1, the same flag that power-on sets.
- R9: The read half of a read-modify-write access returns the enables at bits 5, 2 and 1, and returns 0 at bit 4. Bits 6, 3 and 0 return their cause flags.
- R10: When several enabled sources are active in the same cycle, exactly one flag is set. The priority, highest first, is: supply monitor, pin, missing clock, watchdog, software, flash error, comparator.
- R11: While the reset request is high, register writes are ignored and new source events are not accepted.
- R12: After any reset, exactly one cause flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| por_i | input | 1 | Power-on event, active high, asynchronous |
| vmon_trip_i | input | 1 | Supply-monitor trip pulse |
| pin_rst_i | input | 1 | External reset pin, active high |
| wdt_to_i | input | 1 | Watchdog timeout pulse |
| mcd_to_i | input | 1 | Missing-clock timeout pulse |
| cmp_out_i | input | 1 | Comparator output, trips when low |
| flash_err_i | input | 1 | Flash access error pulse |
| reg_rd_i | input | 1 | Normal read strobe |
| reg_wr_i | input | 1 | Write strobe |
| reg_rmw_i | input | 1 | Read strobe of a read-modify-write access |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, 0 when no read strobe is active |
| sys_rst_o | output | 1 | System reset request |

## Verification
The embedded assertions check properties that hold on every cycle:
- Exactly one cause flag is ever set.
- Bit 7 always reads 0.
- A trigger never overlaps an active reset, and the enables stay frozen while the request is high.
- The hold counter loads and counts down correctly.

The assertions cannot show whether the right source won a tie, or whether a disabled source was truly ignored. Only the bench scenarios can show these, including the dual read views after each kind of reset and the exact 16-cycle width of the request.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

  localparam int unsigned REG_W = 8;
  localparam int unsigned NSRC  = 7;

  // bit positions; software decodes these, so they are fixed
  localparam int unsigned B_PIN   = 0;
  localparam int unsigned B_PWR   = 1;
  localparam int unsigned B_MCD   = 2;
  localparam int unsigned B_WDT   = 3;
  localparam int unsigned B_SW    = 4;
  localparam int unsigned B_CMP   = 5;
  localparam int unsigned B_FLASH = 6;
  localparam int unsigned B_RSVD  = 7;

  localparam logic [NSRC-1:0] FLAGS_AT_POWERUP = NSRC'(1) << B_PWR;

  typedef struct packed {
    logic cmp;
    logic mcd;
    logic vmon;
  } src_en_t;

  localparam src_en_t EN_AT_POWERUP = '{cmp: 1'b0, mcd: 1'b0, vmon: 1'b1};

  // Fixed-priority pick of one cause among the requesting sources.
  function automatic logic [NSRC-1:0] pick_cause(input logic [NSRC-1:0] req);
    logic [NSRC-1:0] r;
    r = '0;
    if      (req[B_PWR])   r[B_PWR]   = 1'b1;
    else if (req[B_PIN])   r[B_PIN]   = 1'b1;
    else if (req[B_MCD])   r[B_MCD]   = 1'b1;
    else if (req[B_WDT])   r[B_WDT]   = 1'b1;
    else if (req[B_SW])    r[B_SW]    = 1'b1;
    else if (req[B_FLASH]) r[B_FLASH] = 1'b1;
    else if (req[B_CMP])   r[B_CMP]   = 1'b1;
    return r;
  endfunction

  // Register image: cause flags for a plain read, enables for a read-modify-write.
  function automatic logic [REG_W-1:0] reg_view(input logic [NSRC-1:0] flags,
                                                input src_en_t en,
                                                input logic rmw);
    logic [REG_W-1:0] v;
    v = {1'b0, flags};
    if (rmw) begin
      v[B_CMP] = en.cmp;
      v[B_SW]  = 1'b0;
      v[B_MCD] = en.mcd;
      v[B_PWR] = en.vmon;
    end
    v[B_RSVD] = 1'b0;
    return v;
  endfunction

  function automatic int unsigned cnt_width(input int unsigned hold);
    return $clog2(hold + 1);
  endfunction

endpackage

// File: rtl/rstc_src_arbiter.sv
module rstc_src_arbiter
  import rstc_pkg::*;
(
  input  logic            vmon_trip_i,
  input  logic            pin_rst_i,
  input  logic            wdt_to_i,
  input  logic            mcd_to_i,
  input  logic            cmp_out_i,
  input  logic            flash_err_i,
  input  logic            sw_force_i,
  input  src_en_t         en_i,
  input  logic            active_i,
  output logic [NSRC-1:0] req_o,
  output logic [NSRC-1:0] cause_o,
  output logic            trig_o
);

  always_comb begin
    req_o          = '0;
    req_o[B_PWR]   = vmon_trip_i & en_i.vmon;
    req_o[B_PIN]   = pin_rst_i;
    req_o[B_MCD]   = mcd_to_i & en_i.mcd;
    req_o[B_WDT]   = wdt_to_i;
    req_o[B_SW]    = sw_force_i;
    req_o[B_FLASH] = flash_err_i;
    req_o[B_CMP]   = ~cmp_out_i & en_i.cmp;
  end

  assign cause_o = pick_cause(req_o);
  assign trig_o  = (|req_o) & ~active_i;

endmodule

// File: rtl/rstc_hold_timer.sv
module rstc_hold_timer #(
  parameter int unsigned HOLD = 16
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic start_i,
  output logic active_o
);

  localparam int unsigned CNT_W = rstc_pkg::cnt_width(HOLD);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(HOLD);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i)              cnt_q <= LOAD;
    else if (start_i)       cnt_q <= LOAD;
    else if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
  end

  assign active_o = (cnt_q != '0);

  // R3
  load_on_start_chk: assert property (@(posedge clk_i) disable iff (por_i)
    start_i |=> cnt_q == LOAD);

  // R3
  countdown_chk: assert property (@(posedge clk_i) disable iff (por_i)
    (active_o && !start_i) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

  // R3
  idle_stays_chk: assert property (@(posedge clk_i) disable iff (por_i)
    (!active_o && !start_i) |=> !active_o);

endmodule

// File: rtl/rstc_csr.sv
module rstc_csr
  import rstc_pkg::*;
(
  input  logic             clk_i,
  input  logic             por_i,
  input  logic             reg_rd_i,
  input  logic             reg_wr_i,
  input  logic             reg_rmw_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  input  logic             trig_i,
  input  logic [NSRC-1:0]  cause_i,
  input  logic             active_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             sw_force_o,
  output src_en_t          en_o
);

  logic [NSRC-1:0] flags_q;
  src_en_t         en_q;
  logic            wr_ok;

  assign wr_ok      = reg_wr_i & ~active_i;
  assign sw_force_o = wr_ok & reg_wdata_i[B_SW];

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i)       flags_q <= FLAGS_AT_POWERUP;
    else if (trig_i) flags_q <= cause_i;
  end

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) begin
      en_q <= EN_AT_POWERUP;
    end else if (wr_ok) begin
      en_q.cmp  <= reg_wdata_i[B_CMP];
      en_q.mcd  <= reg_wdata_i[B_MCD];
      en_q.vmon <= reg_wdata_i[B_PWR];
    end
  end

  assign en_o        = en_q;
  assign reg_rdata_o = (reg_rd_i | reg_rmw_i) ? reg_view(flags_q, en_q, reg_rmw_i) : '0;

  // R12
  one_flag_chk: assert property (@(posedge clk_i) disable iff (por_i)
    $onehot(flags_q));

  // R11
  en_frozen_chk: assert property (@(posedge clk_i) disable iff (por_i)
    active_i |=> $stable(en_q));

  // R11
  flags_frozen_chk: assert property (@(posedge clk_i) disable iff (por_i)
    (active_i && !trig_i) |=> $stable(flags_q));

  // R1
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (por_i)
    reg_rdata_o[B_RSVD] == 1'b0);

endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rstc_pkg::*;
#(
  parameter int unsigned RST_HOLD = 16
) (
  input  logic             clk_i,
  input  logic             por_i,
  input  logic             vmon_trip_i,
  input  logic             pin_rst_i,
  input  logic             wdt_to_i,
  input  logic             mcd_to_i,
  input  logic             cmp_out_i,
  input  logic             flash_err_i,
  input  logic             reg_rd_i,
  input  logic             reg_wr_i,
  input  logic             reg_rmw_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             sys_rst_o
);

  // named internal events
  logic            rst_active;
  logic            rst_trig;
  logic            sw_force;
  logic [NSRC-1:0] src_req;
  logic [NSRC-1:0] src_cause;
  src_en_t         src_en;

  rstc_src_arbiter u_arb (
    .vmon_trip_i (vmon_trip_i),
    .pin_rst_i   (pin_rst_i),
    .wdt_to_i    (wdt_to_i),
    .mcd_to_i    (mcd_to_i),
    .cmp_out_i   (cmp_out_i),
    .flash_err_i (flash_err_i),
    .sw_force_i  (sw_force),
    .en_i        (src_en),
    .active_i    (rst_active),
    .req_o       (src_req),
    .cause_o     (src_cause),
    .trig_o      (rst_trig)
  );

  rstc_hold_timer #(.HOLD(RST_HOLD)) u_timer (
    .clk_i    (clk_i),
    .por_i    (por_i),
    .start_i  (rst_trig),
    .active_o (rst_active)
  );

  rstc_csr u_csr (
    .clk_i       (clk_i),
    .por_i       (por_i),
    .reg_rd_i    (reg_rd_i),
    .reg_wr_i    (reg_wr_i),
    .reg_rmw_i   (reg_rmw_i),
    .reg_wdata_i (reg_wdata_i),
    .trig_i      (rst_trig),
    .cause_i     (src_cause),
    .active_i    (rst_active),
    .reg_rdata_o (reg_rdata_o),
    .sw_force_o  (sw_force),
    .en_o        (src_en)
  );

  assign sys_rst_o = rst_active;

  // R10
  single_cause_chk: assert property (@(posedge clk_i) disable iff (por_i)
    rst_trig |-> $onehot(src_cause));

  // R11
  no_trig_in_reset_chk: assert property (@(posedge clk_i) disable iff (por_i)
    rst_active |-> !rst_trig);

  // R3
  trig_raises_rst_chk: assert property (@(posedge clk_i) disable iff (por_i)
    rst_trig |=> sys_rst_o);

  // R4
  pin_always_trips_chk: assert property (@(posedge clk_i) disable iff (por_i)
    (pin_rst_i && !sys_rst_o) |=> sys_rst_o);

endmodule

// File: tb/test_rst_cause_reg.sv
module test_rst_cause_reg;

  logic       clk = 1'b0;
  logic       por, vmon, pin, wdt, mcd, cmp_out, flash;
  logic       rd, wr, rmw;
  logic [7:0] wdata, rdata;
  logic       rst;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  rst_cause_reg i_rst_cause_reg (
    .clk_i(clk), .por_i(por), .vmon_trip_i(vmon), .pin_rst_i(pin),
    .wdt_to_i(wdt), .mcd_to_i(mcd), .cmp_out_i(cmp_out), .flash_err_i(flash),
    .reg_rd_i(rd), .reg_wr_i(wr), .reg_rmw_i(rmw), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .sys_rst_o(rst)
  );

  // pulse bits: 0 pin, 1 supply monitor, 2 missing clock, 3 watchdog,
  // 4 software write, 5 flash error, 6 comparator low
  typedef struct packed {
    logic [7:0] en;
    logic [6:0] pulse;
    logic       exp_rst;
    logic [7:0] exp_rd;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{8'h02, 7'h01, 1'b1, 8'h01},  // R4 pin
    '{8'h02, 7'h08, 1'b1, 8'h08},  // R4 watchdog
    '{8'h02, 7'h20, 1'b1, 8'h40},  // R4 flash
    '{8'h02, 7'h04, 1'b0, 8'h40},  // R6 missing clock disabled
    '{8'h06, 7'h04, 1'b1, 8'h04},  // R6 missing clock enabled
    '{8'h06, 7'h40, 1'b0, 8'h04},  // R7 comparator disabled
    '{8'h26, 7'h40, 1'b1, 8'h20},  // R7 comparator enabled
    '{8'h20, 7'h02, 1'b0, 8'h20},  // R8 monitor disabled
    '{8'h22, 7'h02, 1'b1, 8'h02},  // R8 monitor enabled
    '{8'h02, 7'h10, 1'b1, 8'h10},  // R5 software force
    '{8'h06, 7'h0D, 1'b1, 8'h01},  // R10 pin over mcd, wdt
    '{8'h26, 7'h6C, 1'b1, 8'h04},  // R10 mcd over wdt, flash, cmp
    '{8'h26, 7'h78, 1'b1, 8'h08},  // R10 wdt over sw, flash, cmp
    '{8'h26, 7'h70, 1'b1, 8'h10},  // R10 sw over flash, cmp
    '{8'h26, 7'h60, 1'b1, 8'h40},  // R10 flash over cmp
    '{8'h22, 7'h03, 1'b1, 8'h02}   // R10 monitor over pin
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] d);
    wr = 1'b1; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = 8'h00;
  endtask

  task automatic read_both(input string req, input logic [7:0] exp_plain,
                           input logic [7:0] exp_rmw);
    rd = 1'b1; #1;
    chk(req, rdata, exp_plain);
    rd = 1'b0; rmw = 1'b1; #1;
    chk(req, rdata, exp_rmw);
    rmw = 1'b0;
    @(negedge clk);
  endtask

  task automatic count_hold(output int n);
    n = 0;
    while (rst && n < 40) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    por = 1'b1; vmon = 0; pin = 0; wdt = 0; mcd = 0; cmp_out = 1'b1; flash = 0;
    rd = 0; wr = 0; rmw = 0; wdata = 8'h00;
    #1;
    chk("R2 async request", {7'b0, rst}, 8'h01);
    repeat (3) @(negedge clk);
    por = 1'b0;
    count_hold(n);
    chk("R3 power-on hold", 8'(n), 8'd16);
    read_both("R2 power-on state", 8'h02, 8'h02);

    for (int i = 0; i < NV; i++) begin
      do_write(VECS[i].en & 8'h26);
      pin = VECS[i].pulse[0]; vmon = VECS[i].pulse[1]; mcd = VECS[i].pulse[2];
      wdt = VECS[i].pulse[3]; flash = VECS[i].pulse[5]; cmp_out = ~VECS[i].pulse[6];
      if (VECS[i].pulse[4]) begin wr = 1'b1; wdata = VECS[i].en | 8'h10; end
      @(negedge clk);
      pin = 0; vmon = 0; mcd = 0; wdt = 0; flash = 0; cmp_out = 1'b1;
      wr = 1'b0; wdata = 8'h00;
      chk($sformatf("R3 vector %0d request", i), {7'b0, rst}, {7'b0, VECS[i].exp_rst});
      repeat (20) @(negedge clk);
      read_both($sformatf("R9 vector %0d read", i), VECS[i].exp_rd,
                (VECS[i].en & 8'h26) | (VECS[i].exp_rd & 8'h49));
    end

    // R3: exact hold width after a pin event
    pin = 1'b1; @(negedge clk); pin = 1'b0;
    count_hold(n);
    chk("R3 pin hold", 8'(n), 8'd16);
    repeat (2) @(negedge clk);

    // R11: writes and events during an active request are ignored
    pin = 1'b1; @(negedge clk); pin = 1'b0;
    do_write(8'h90);
    wdt = 1'b1; @(negedge clk); wdt = 1'b0;
    repeat (20) @(negedge clk);
    read_both("R11 ignored in reset", 8'h01, 8'h23);

    // R1 and R5: bit 7 ignored, writing 0 to bit 4 does nothing
    do_write(8'hA2);
    chk("R5 zero write no reset", {7'b0, rst}, 8'h00);
    read_both("R1 bit 7", 8'h01, 8'h23);

    // R2: power-on mid-run restores defaults
    do_write(8'h26);
    por = 1'b1; #1;
    chk("R2 async request", {7'b0, rst}, 8'h01);
    @(negedge clk); por = 1'b0;
    repeat (20) @(negedge clk);
    read_both("R2 restored", 8'h02, 8'h02);

    // R12: single flag after a multi-source reset
    do_write(8'h26);
    wdt = 1'b1; flash = 1'b1; @(negedge clk); wdt = 0; flash = 0;
    repeat (20) @(negedge clk);
    read_both("R12 one flag", 8'h08, 8'h2E);

    finish_run();
  end

endmodule